// File: doc/BRIEF.md
# Data Access Permission and Fault-Status Unit

This unit sits in front of a data translation buffer. Each request carries a virtual address, a size, a write flag and an address-space identifier (ASI). The unit combines these with the current processor state: trap level non-zero, privileged, hypervisor, reset mode, 32-bit address masking and data-translation enable. From them it picks the context used for the lookup and decides whether the access bypasses translation.

When the access does not bypass, the unit drives a combinational lookup port on the external buffer. It then runs a fixed chain of checks: identifier privilege, alignment, address hole, miss, write protection, no-fault page and privileged page. One cycle after the request it returns either a physical address with an uncacheable flag, or exactly one fault code.

Faults that record status load a fault status word and a fault address register. Translation misses load a tag-access register instead.

Top module: `mmu_access_chk`

## Requirements
- R1: After reset, rsp_valid is 0 and fsr, far and tag_access are all zero.
- R2: A request made with the hypervisor bit or the reset-mode bit set completes with fault code 0. Its rsp_pa is req_va truncated to PA_W bits, and no alignment or hole check applies. The one exception is an explicit request with the real identifier 0x14, which is translated instead.
- R3: The lookup context depends on the trap level and the identifier. With trap level non-zero it is 0. Otherwise, identifier 0x00 (implicit) and user identifiers with bit 0 clear use ctx_primary. User identifiers (0x80 and above) with bit 0 set use ctx_secondary.
- R4: req_size n selects 2^n bytes. A request whose address is not a multiple of its size raises fault code 1 (misalignment), whatever the lookup returns.
- R5: When data translation is disabled in a non-hypervisor mode, or the identifier is 0x14, the lookup is made in real mode: tlb_real is 1 and tlb_ctx is 0.
- R6: With address masking on, tlb_va is req_va truncated to 32 bits and no hole check applies. With masking off, an address inside [HOLE_LO, HOLE_HI] raises fault code 2, with fault type 4 and the side-effect bit set.
- R7: A miss raises fault code 3 in real mode and fault code 4 otherwise. It loads tag_access with the page-aligned effective address ORed with the lookup context, and it leaves fsr and far unchanged.
- R8: On a hit, the checks run in this order, and the first that applies decides the fault:
  - a write to a non-writable page gives code 5, fault type 0;
  - a no-fault page accessed without a no-fault identifier (a user identifier with bit 1 set) gives code 6, fault type 2;
  - a privileged page accessed in user mode gives code 6, fault type 1.
- R9: A successful hit on a side-effect page sets rsp_uncache. rsp_uncache is never set together with a fault.
- R10: Every fault with code 1, 2, 5, 6 or 7 writes fsr and loads far with req_va. The fsr fields are:
  - bit 0: valid, written as 1;
  - bit 1: overwrite, the previous valid bit;
  - bit 2: write flag;
  - bits 5:4: context type (0 primary, 1 secondary, 2 nucleus);
  - bit 6: side-effect;
  - bits 11:7: fault type;
  - bits 23:16: identifier.
- R11: A successful hit returns, one cycle after the request, tlb_pa bits where tlb_off_mask is 0 and effective-address bits where it is 1.
- R12: The identifier is checked in non-hypervisor, non-reset modes. In user mode, an explicit identifier below 0x80 raises code 7. In privileged mode, an identifier 0x30 to 0x7F raises code 6. Both faults use fault type 3 and context type nucleus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | VA_W | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store access |
| req_asi | input | 8 | Address-space identifier, 0 for implicit |
| st_tl_nz | input | 1 | Trap level above zero |
| st_priv | input | 1 | Privileged mode |
| st_hyp | input | 1 | Hypervisor mode |
| st_red | input | 1 | Reset/error mode |
| st_amask | input | 1 | 32-bit address masking enabled |
| st_dmmu_en | input | 1 | Data translation enabled |
| ctx_primary | input | CTX_W | Primary context |
| ctx_secondary | input | CTX_W | Secondary context |
| tlb_va | output | VA_W | Lookup address (effective) |
| tlb_ctx | output | CTX_W | Lookup context |
| tlb_real | output | 1 | Lookup in real-address space |
| tlb_hit | input | 1 | Lookup found a valid entry |
| tlb_pa | input | PA_W | Entry physical address |
| tlb_off_mask | input | PA_W | Entry page-offset mask |
| tlb_writable | input | 1 | Entry writable |
| tlb_nofault | input | 1 | Entry is no-fault only |
| tlb_side | input | 1 | Entry has side effects |
| tlb_priv | input | 1 | Entry is privileged |
| rsp_valid | output | 1 | Result valid (one cycle after request) |
| rsp_fault | output | 3 | Fault code, 0 for none |
| rsp_pa | output | PA_W | Physical address when no fault |
| rsp_uncache | output | 1 | Access must bypass caches |
| fsr | output | 24 | Fault status word |
| far | output | VA_W | Fault address |
| tag_access | output | VA_W | Miss tag: page address ORed with context |

## Verification
The bench builds the unit with its default parameters:
- a 64-bit virtual address and a 40-bit physical address;
- 13-bit contexts and 8 KB pages;
- the hole check enabled, spanning 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF.

The hole's lower bound is therefore a reachable address. The bench can show that masking that same address to 32 bits clears the fault, and it can push an address whose upper 32 bits are set through truncation. The 40-bit width lets bypass requests show that upper bits are dropped. The 13-bit context fills the whole in-page field of the tag-access word.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

   localparam int ASI_W  = 8;
   localparam int SFSR_W = 16 + ASI_W;

   typedef enum logic [2:0] {
      FLT_NONE        = 3'd0,
      FLT_MISALIGN    = 3'd1,
      FLT_VA_RANGE    = 3'd2,
      FLT_REAL_MISS   = 3'd3,
      FLT_MMU_MISS    = 3'd4,
      FLT_PROTECT     = 3'd5,
      FLT_ACCESS      = 3'd6,
      FLT_PRIV_ACTION = 3'd7
   } flt_e;

   typedef enum logic [1:0] {
      CT_PRIMARY   = 2'd0,
      CT_SECONDARY = 2'd1,
      CT_NUCLEUS   = 2'd2
   } ctx_type_e;

   typedef enum logic [4:0] {
      FT_OTHER     = 5'd0,
      FT_PRIV_VIOL = 5'd1,
      FT_NF_LOAD   = 5'd2,
      FT_ILL_ASI   = 5'd3,
      FT_VA_RANGE  = 5'd4
   } ftype_e;

   localparam logic [ASI_W-1:0] ASI_IMPLICIT = 8'h00;
   localparam logic [ASI_W-1:0] ASI_REAL     = 8'h14;
   localparam logic [ASI_W-1:0] ASI_HYP_LO   = 8'h30;

   function automatic logic asi_user_ok(input logic [ASI_W-1:0] a);
      return a[ASI_W-1];
   endfunction

   function automatic logic asi_hyp_only(input logic [ASI_W-1:0] a);
      return !a[ASI_W-1] && (a >= ASI_HYP_LO);
   endfunction

   function automatic logic asi_secondary(input logic [ASI_W-1:0] a);
      return a[ASI_W-1] && a[0];
   endfunction

   function automatic logic asi_nofault(input logic [ASI_W-1:0] a);
      return a[ASI_W-1] && a[1];
   endfunction

   function automatic logic flt_records(input flt_e f);
      return (f == FLT_MISALIGN) || (f == FLT_VA_RANGE) || (f == FLT_PROTECT) ||
             (f == FLT_ACCESS) || (f == FLT_PRIV_ACTION);
   endfunction

   function automatic logic flt_is_miss(input flt_e f);
      return (f == FLT_REAL_MISS) || (f == FLT_MMU_MISS);
   endfunction

endpackage

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel
   import mmu_chk_pkg::*;
#(
   parameter int CTX_W = 13
) (
   input  logic [ASI_W-1:0] asi,
   input  logic             tl_nz,
   input  logic             priv,
   input  logic             hyp,
   input  logic             red,
   input  logic             dmmu_en,
   input  logic [CTX_W-1:0] ctx_pri,
   input  logic [CTX_W-1:0] ctx_sec,
   output ctx_type_e        ct,
   output logic [CTX_W-1:0] lookup_ctx,
   output logic             lookup_real,
   output logic             bypass,
   output flt_e             asi_fault,
   output logic             nf_ok
);

   logic implicit_a;
   logic real_asi;
   logic [CTX_W-1:0] base_ctx;

   always_comb begin
      implicit_a = (asi == ASI_IMPLICIT);
      real_asi   = !implicit_a && (asi == ASI_REAL);

      if (tl_nz)                                  ct = CT_NUCLEUS;
      else if (!implicit_a && asi_secondary(asi)) ct = CT_SECONDARY;
      else                                        ct = CT_PRIMARY;

      unique case (ct)
         CT_NUCLEUS:   base_ctx = '0;
         CT_SECONDARY: base_ctx = ctx_sec;
         default:      base_ctx = ctx_pri;
      endcase

      lookup_real = (!dmmu_en && !hyp) || real_asi;
      lookup_ctx  = lookup_real ? '0 : base_ctx;
      bypass      = (hyp || red) && !real_asi;
      nf_ok       = !implicit_a && asi_nofault(asi);

      asi_fault = FLT_NONE;
      if (!implicit_a && !hyp && !red) begin
         if (!priv && !asi_user_ok(asi))      asi_fault = FLT_PRIV_ACTION;
         else if (priv && asi_hyp_only(asi))  asi_fault = FLT_ACCESS;
      end
   end

endmodule

// File: rtl/mmu_check_eval.sv
module mmu_check_eval
   import mmu_chk_pkg::*;
#(
   parameter int              VA_W    = 64,
   parameter int              PA_W    = 40,
   parameter int              AMASK_W = 32,
   parameter bit              HOLE_EN = 1'b1,
   parameter logic [VA_W-1:0] HOLE_LO = '0,
   parameter logic [VA_W-1:0] HOLE_HI = '0
) (
   input  logic [VA_W-1:0] va,
   input  logic [1:0]      size,
   input  logic            write,
   input  logic            amask,
   input  logic            priv,
   input  logic            bypass,
   input  logic            lookup_real,
   input  flt_e            asi_fault,
   input  logic            nf_ok,
   input  ctx_type_e       ct,
   input  logic            tlb_hit,
   input  logic [PA_W-1:0] tlb_pa,
   input  logic [PA_W-1:0] tlb_off_mask,
   input  logic            tlb_writable,
   input  logic            tlb_nofault,
   input  logic            tlb_side,
   input  logic            tlb_priv,
   output logic [VA_W-1:0] va_eff,
   output flt_e            fault,
   output ftype_e          ftype,
   output ctx_type_e       fs_ct,
   output logic            fs_side,
   output logic [PA_W-1:0] pa,
   output logic            uncache
);

   logic [2:0] low_mask;
   logic       misaligned;
   logic       in_hole;

   always_comb begin
      va_eff = va;
      if (amask) begin
         va_eff = '0;
         va_eff[AMASK_W-1:0] = va[AMASK_W-1:0];
      end
      low_mask   = 3'((4'd1 << size) - 4'd1);
      misaligned = |(va[2:0] & low_mask);
   end

   generate
      if (HOLE_EN) begin : g_hole
         assign in_hole = !amask && (va_eff >= HOLE_LO) && (va_eff <= HOLE_HI);
      end else begin : g_no_hole
         assign in_hole = 1'b0;
      end
   endgenerate

   always_comb begin
      fault   = FLT_NONE;
      ftype   = FT_OTHER;
      fs_ct   = ct;
      fs_side = 1'b0;
      pa      = '0;
      uncache = 1'b0;
      if (bypass) begin
         pa = va[PA_W-1:0];
      end else if (asi_fault != FLT_NONE) begin
         fault = asi_fault;
         ftype = FT_ILL_ASI;
         fs_ct = CT_NUCLEUS;
      end else if (misaligned) begin
         fault = FLT_MISALIGN;
      end else if (in_hole) begin
         fault   = FLT_VA_RANGE;
         ftype   = FT_VA_RANGE;
         fs_side = 1'b1;
      end else if (!tlb_hit) begin
         fault = lookup_real ? FLT_REAL_MISS : FLT_MMU_MISS;
      end else if (write && !tlb_writable) begin
         fault   = FLT_PROTECT;
         fs_side = tlb_side;
      end else if (tlb_nofault && !nf_ok) begin
         fault   = FLT_ACCESS;
         ftype   = FT_NF_LOAD;
         fs_side = tlb_side;
      end else if (!priv && tlb_priv) begin
         fault   = FLT_ACCESS;
         ftype   = FT_PRIV_VIOL;
         fs_side = tlb_side;
      end else begin
         pa      = (tlb_pa & ~tlb_off_mask) | (va_eff[PA_W-1:0] & tlb_off_mask);
         uncache = tlb_side;
      end
   end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
   import mmu_chk_pkg::*;
#(
   parameter int VA_W    = 64,
   parameter int CTX_W   = 13,
   parameter int PAGE_SH = 13
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    evt_valid,
   input  flt_e                    fault,
   input  ftype_e                  ftype,
   input  ctx_type_e               ct,
   input  logic                    side,
   input  logic                    write,
   input  logic [ASI_W-1:0]        asi,
   input  logic [VA_W-1:0]         va,
   input  logic [VA_W-PAGE_SH-1:0] va_page,
   input  logic [CTX_W-1:0]        ctx,
   output logic [SFSR_W-1:0]       sfsr,
   output logic [VA_W-1:0]         sfar,
   output logic [VA_W-1:0]         tag
);

   logic [PAGE_SH-1:0] ctx_ext;

   always_comb begin
      ctx_ext = '0;
      ctx_ext[CTX_W-1:0] = ctx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sfsr <= '0;
         sfar <= '0;
         tag  <= '0;
      end else if (evt_valid) begin
         if (flt_records(fault)) begin
            sfsr <= {asi, 4'b0000, ftype, side, ct, 1'b0, write, sfsr[0], 1'b1};
            sfar <= va;
         end
         if (flt_is_miss(fault)) begin
            tag <= {va_page, ctx_ext};
         end
      end
   end

   AST_OVW_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
      (sfsr[1] && !$past(sfsr[1])) |-> $past(sfsr[0])); // R10

   AST_MISS_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && flt_is_miss(fault)) |=> $stable(sfsr)); // R7

endmodule

// File: rtl/mmu_access_chk.sv
module mmu_access_chk
   import mmu_chk_pkg::*;
#(
   parameter int              VA_W    = 64,
   parameter int              PA_W    = 40,
   parameter int              CTX_W   = 13,
   parameter int              PAGE_SH = 13,
   parameter int              AMASK_W = 32,
   parameter bit              HOLE_EN = 1'b1,
   parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
   parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [1:0]        req_size,
   input  logic              req_write,
   input  logic [7:0]        req_asi,
   input  logic              st_tl_nz,
   input  logic              st_priv,
   input  logic              st_hyp,
   input  logic              st_red,
   input  logic              st_amask,
   input  logic              st_dmmu_en,
   input  logic [CTX_W-1:0]  ctx_primary,
   input  logic [CTX_W-1:0]  ctx_secondary,
   output logic [VA_W-1:0]   tlb_va,
   output logic [CTX_W-1:0]  tlb_ctx,
   output logic              tlb_real,
   input  logic              tlb_hit,
   input  logic [PA_W-1:0]   tlb_pa,
   input  logic [PA_W-1:0]   tlb_off_mask,
   input  logic              tlb_writable,
   input  logic              tlb_nofault,
   input  logic              tlb_side,
   input  logic              tlb_priv,
   output logic              rsp_valid,
   output logic [2:0]        rsp_fault,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_uncache,
   output logic [23:0]       fsr,
   output logic [VA_W-1:0]   far,
   output logic [VA_W-1:0]   tag_access
);

   localparam int PAGE_W = VA_W - PAGE_SH;

   generate
      if (CTX_W > PAGE_SH) begin : g_err_ctx
         $error("context must fit inside the page offset");
      end
      if (PA_W > VA_W) begin : g_err_pa
         $error("physical width exceeds virtual width");
      end
      if (AMASK_W >= VA_W || AMASK_W < 3) begin : g_err_am
         $error("mask width out of range");
      end
      if (SFSR_W != 24) begin : g_err_fs
         $error("status word width mismatch");
      end
   endgenerate

   ctx_type_e ct;
   ctx_type_e fs_ct;
   flt_e      asi_fault;
   flt_e      fault;
   ftype_e    ftype;
   logic      bypass;
   logic      nf_ok;
   logic      fs_side;
   logic      uncache;
   logic [PA_W-1:0] pa;

   mmu_ctx_sel #(.CTX_W(CTX_W)) u_ctx (
      .asi         (req_asi),
      .tl_nz       (st_tl_nz),
      .priv        (st_priv),
      .hyp         (st_hyp),
      .red         (st_red),
      .dmmu_en     (st_dmmu_en),
      .ctx_pri     (ctx_primary),
      .ctx_sec     (ctx_secondary),
      .ct          (ct),
      .lookup_ctx  (tlb_ctx),
      .lookup_real (tlb_real),
      .bypass      (bypass),
      .asi_fault   (asi_fault),
      .nf_ok       (nf_ok)
   );

   mmu_check_eval #(
      .VA_W(VA_W), .PA_W(PA_W), .AMASK_W(AMASK_W),
      .HOLE_EN(HOLE_EN), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
   ) u_eval (
      .va           (req_va),
      .size         (req_size),
      .write        (req_write),
      .amask        (st_amask),
      .priv         (st_priv),
      .bypass       (bypass),
      .lookup_real  (tlb_real),
      .asi_fault    (asi_fault),
      .nf_ok        (nf_ok),
      .ct           (ct),
      .tlb_hit      (tlb_hit),
      .tlb_pa       (tlb_pa),
      .tlb_off_mask (tlb_off_mask),
      .tlb_writable (tlb_writable),
      .tlb_nofault  (tlb_nofault),
      .tlb_side     (tlb_side),
      .tlb_priv     (tlb_priv),
      .va_eff       (tlb_va),
      .fault        (fault),
      .ftype        (ftype),
      .fs_ct        (fs_ct),
      .fs_side      (fs_side),
      .pa           (pa),
      .uncache      (uncache)
   );

   mmu_fault_regs #(.VA_W(VA_W), .CTX_W(CTX_W), .PAGE_SH(PAGE_SH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (req_valid),
      .fault     (fault),
      .ftype     (ftype),
      .ct        (fs_ct),
      .side      (fs_side),
      .write     (req_write),
      .asi       (req_asi),
      .va        (req_va),
      .va_page   (tlb_va[VA_W-1:PAGE_SH]),
      .ctx       (tlb_ctx),
      .sfsr      (fsr),
      .sfar      (far),
      .tag       (tag_access)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_fault   <= FLT_NONE;
         rsp_pa      <= '0;
         rsp_uncache <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         rsp_fault   <= req_valid ? fault : FLT_NONE;
         rsp_pa      <= req_valid ? pa : '0;
         rsp_uncache <= req_valid && uncache;
      end
   end

   logic [PAGE_W-1:0] unused_page_chk;
   assign unused_page_chk = tlb_va[VA_W-1:PAGE_SH];

   AST_BYPASS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && st_hyp && req_asi == 8'h00)
      |=> (rsp_valid && rsp_fault == 3'd0 && rsp_pa == $past(req_va[PA_W-1:0]))); // R2

   AST_MISALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_asi == 8'h00 && !st_hyp && !st_red &&
       (|(req_va[2:0] & 3'((4'd1 << req_size) - 4'd1))))
      |=> (rsp_fault == 3'd1)); // R4

   AST_UNCACHE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_uncache) |-> (rsp_fault == 3'd0)); // R9

   AST_FAR_ON_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (rsp_fault == 3'd1 || rsp_fault == 3'd2 || rsp_fault >= 3'd5))
      |-> (far == $past(req_va) && fsr[0])); // R10

endmodule

// File: tb/mmu_access_chk_tb.sv
`timescale 1ns/1ps
module mmu_access_chk_tb;

   typedef struct {
      string       nm;
      logic [2:0]  f;
      logic [39:0] pa;
      logic        unc;
      logic [23:0] fsr;
      logic [63:0] far;
      logic [63:0] tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        req_valid = 0;
   logic [63:0] req_va = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 0;
   logic [7:0]  req_asi = '0;
   logic st_tl_nz = 0, st_priv = 1, st_hyp = 0, st_red = 0, st_amask = 0, st_dmmu_en = 1;
   logic [12:0] ctx_primary = 13'h0123, ctx_secondary = 13'h0456;
   logic [63:0] tlb_va;
   logic [12:0] tlb_ctx;
   logic        tlb_real;
   logic        tlb_hit = 1;
   logic [39:0] tlb_pa = 40'hAB_CDE0_0000;
   logic [39:0] tlb_off_mask = 40'h00_0000_1FFF;
   logic tlb_writable = 1, tlb_nofault = 0, tlb_side = 0, tlb_priv = 0;
   logic        rsp_valid;
   logic [2:0]  rsp_fault;
   logic [39:0] rsp_pa;
   logic        rsp_uncache;
   logic [23:0] fsr;
   logic [63:0] far;
   logic [63:0] tag_access;

   mmu_access_chk u_dut (
      .clk, .rst_n, .req_valid, .req_va, .req_size, .req_write, .req_asi,
      .st_tl_nz, .st_priv, .st_hyp, .st_red, .st_amask, .st_dmmu_en,
      .ctx_primary, .ctx_secondary, .tlb_va, .tlb_ctx, .tlb_real,
      .tlb_hit, .tlb_pa, .tlb_off_mask, .tlb_writable, .tlb_nofault,
      .tlb_side, .tlb_priv, .rsp_valid, .rsp_fault, .rsp_pa, .rsp_uncache,
      .fsr, .far, .tag_access
   );

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;
   item_t sb[$];
   logic [23:0] e_fsr = '0;
   logic [63:0] e_far = '0;
   logic [63:0] e_tag = '0;

   task automatic chk(string nm, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", nm, act, exp);
      end
   endtask

   // driver: applies one request, pushes expected result into the scoreboard
   task automatic send(string nm, logic [63:0] va, logic [1:0] sz, logic wr,
                       logic [7:0] asi, logic [2:0] ef, logic [39:0] epa, logic eu,
                       logic [4:0] eft, logic [1:0] ect, logic ese,
                       logic [12:0] ectx, logic lk, logic ereal);
      item_t it;
      logic [63:0] vae;
      @(negedge clk);
      req_valid = 1; req_va = va; req_size = sz; req_write = wr; req_asi = asi;
      vae = st_amask ? {32'h0, va[31:0]} : va;
      if (ef == 3'd1 || ef == 3'd2 || ef >= 3'd5) begin
         e_fsr = {asi, 4'b0, eft, ese, ect, 1'b0, wr, e_fsr[0], 1'b1};
         e_far = va;
      end
      if (ef == 3'd3 || ef == 3'd4) e_tag = {vae[63:13], 13'h0} | {51'h0, ectx};
      it.nm = nm; it.f = ef; it.pa = epa; it.unc = eu;
      it.fsr = e_fsr; it.far = e_far; it.tag = e_tag;
      sb.push_back(it);
      #1;
      if (lk) begin
         chk({nm, " lookup ctx"}, 64'(tlb_ctx), 64'(ectx));
         chk({nm, " lookup real"}, 64'(tlb_real), 64'(ereal));
         chk({nm, " lookup va"}, tlb_va, vae);
      end
      @(posedge clk);
      #1;
      req_valid = 0;
   endtask

   // monitor: compares every response against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL unexpected response: actual fault %0d expected none queued", rsp_fault);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk({it.nm, " fault"}, 64'(rsp_fault), 64'(it.f));
            if (it.f == 3'd0) chk({it.nm, " pa"}, 64'(rsp_pa), 64'(it.pa));
            chk({it.nm, " uncache"}, 64'(rsp_uncache), 64'(it.unc));
            chk({it.nm, " fsr"}, 64'(fsr), 64'(it.fsr));
            chk({it.nm, " far"}, far, it.far);
            chk({it.nm, " tag"}, tag_access, it.tag);
         end
      end
   end

   task automatic idle();
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1 reset fsr", 64'(fsr), 64'd0);
      chk("R1 reset far", far, 64'd0);
      chk("R1 reset tag", tag_access, 64'd0);
      rst_n = 1;
      idle();

      // R3 R11: implicit hit, primary context, 8K page
      send("R3_R11 implicit primary", 64'h0000_0000_1234_5678, 2'd2, 0, 8'h00,
           3'd0, 40'hAB_CDE0_1678, 0, 0, 0, 0, 13'h0123, 1, 0);
      st_tl_nz = 1;
      send("R3 nucleus ctx", 64'h0000_0000_1234_5678, 2'd2, 0, 8'h00,
           3'd0, 40'hAB_CDE0_1678, 0, 0, 0, 0, 13'h0000, 1, 0);
      st_tl_nz = 0;
      tlb_off_mask = 40'h00_0000_FFFF;
      send("R11 64K page", 64'h0000_0000_1234_5678, 2'd3, 0, 8'h00,
           3'd0, 40'hAB_CDE0_5678, 0, 0, 0, 0, 13'h0123, 0, 0);
      tlb_off_mask = 40'h00_0000_1FFF;
      st_priv = 0;
      send("R3 secondary asi", 64'h0000_0000_0000_2040, 2'd3, 0, 8'h81,
           3'd0, 40'hAB_CDE0_0040, 0, 0, 0, 0, 13'h0456, 1, 0);
      st_priv = 1;

      // R2: bypass in hypervisor and in reset mode, misaligned ignored
      st_hyp = 1; tlb_hit = 0;
      send("R2 hyp bypass", 64'hFFFF_FF12_3456_7891, 2'd3, 1, 8'h00,
           3'd0, 40'h12_3456_7891, 0, 0, 0, 0, 13'h0, 0, 0);
      st_hyp = 0; st_red = 1;
      send("R2 red bypass", 64'h0000_8000_0000_0005, 2'd2, 0, 8'h00,
           3'd0, 40'h00_0000_0005, 0, 0, 0, 0, 13'h0, 0, 0);
      st_red = 0; st_hyp = 1; tlb_hit = 1;
      send("R2_R5 hyp real asi", 64'h0000_0000_0000_3008, 2'd3, 0, 8'h14,
           3'd0, 40'hAB_CDE0_1008, 0, 0, 0, 0, 13'h0, 1, 1);
      st_hyp = 0;

      // R4: misalignment wins over a miss
      tlb_hit = 0;
      send("R4 misalign", 64'h0000_0000_0000_1004, 2'd3, 1, 8'h00,
           3'd1, 40'h0, 0, 5'd0, 2'd0, 0, 13'h0, 0, 0);
      tlb_hit = 1;
      send("R4 halfword odd", 64'h0000_0000_0000_1001, 2'd1, 0, 8'h00,
           3'd1, 40'h0, 0, 5'd0, 2'd0, 0, 13'h0, 0, 0);

      // R6: hole and address masking
      send("R6_R10 hole", 64'h0000_8000_0000_0000, 2'd3, 0, 8'h00,
           3'd2, 40'h0, 0, 5'd4, 2'd0, 1, 13'h0, 0, 0);
      st_amask = 1;
      send("R6 masked", 64'h0000_8000_0000_0000, 2'd3, 0, 8'h00,
           3'd0, 40'hAB_CDE0_0000, 0, 0, 0, 0, 13'h0123, 1, 0);
      send("R6 truncate", 64'hFFFF_FFFF_0000_2468, 2'd2, 0, 8'h00,
           3'd0, 40'hAB_CDE0_0468, 0, 0, 0, 0, 13'h0123, 1, 0);
      st_amask = 0;

      // R7 R5: misses
      tlb_hit = 0;
      send("R7 mmu miss", 64'h0000_0000_4000_3ABC, 2'd0, 0, 8'h00,
           3'd4, 40'h0, 0, 0, 0, 0, 13'h0123, 1, 0);
      st_dmmu_en = 0;
      send("R5_R7 real miss", 64'h0000_0000_4000_3ABC, 2'd0, 0, 8'h00,
           3'd3, 40'h0, 0, 0, 0, 0, 13'h0000, 1, 1);
      st_dmmu_en = 1; tlb_hit = 1;

      // R8: ordered post-hit checks
      tlb_writable = 0; tlb_nofault = 1; tlb_side = 1; tlb_priv = 1; st_priv = 0;
      send("R8 protect first", 64'h0000_0000_0000_0010, 2'd3, 1, 8'h00,
           3'd5, 40'h0, 0, 5'd0, 2'd0, 1, 13'h0, 0, 0);
      tlb_writable = 1; tlb_side = 0;
      send("R8 nofault page", 64'h0000_0000_0000_0010, 2'd3, 0, 8'h00,
           3'd6, 40'h0, 0, 5'd2, 2'd0, 0, 13'h0, 0, 0);
      tlb_nofault = 0;
      send("R8 priv page", 64'h0000_0000_0000_0010, 2'd3, 0, 8'h00,
           3'd6, 40'h0, 0, 5'd1, 2'd0, 0, 13'h0, 0, 0);
      tlb_priv = 0; tlb_nofault = 1;
      send("R8 nofault asi ok", 64'h0000_0000_0000_0018, 2'd3, 0, 8'h82,
           3'd0, 40'hAB_CDE0_0018, 0, 0, 0, 0, 13'h0123, 0, 0);
      tlb_nofault = 0; st_priv = 1;

      // R9: side-effect page
      tlb_side = 1;
      send("R9 uncache", 64'h0000_0000_0000_0020, 2'd3, 0, 8'h00,
           3'd0, 40'hAB_CDE0_0020, 1, 0, 0, 0, 13'h0123, 0, 0);
      tlb_side = 0;

      // R12: identifier privilege
      st_priv = 0;
      send("R12 priv action", 64'h0000_0000_0000_0040, 2'd3, 0, 8'h04,
           3'd7, 40'h0, 0, 5'd3, 2'd2, 0, 13'h0, 0, 0);
      st_priv = 1;
      send("R12_R10 hyp asi", 64'h0000_0000_0000_0048, 2'd3, 1, 8'h40,
           3'd6, 40'h0, 0, 5'd3, 2'd2, 0, 13'h0, 0, 0);

      idle();
      chk("R10 overwrite bit held", 64'(fsr[1:0]), 64'd3);
      chk("scoreboard drained", 64'(sb.size()), 64'd0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule